// File: doc/BRIEF.md
# Segmented Address and Byte-Lane Generator

This block takes one memory request made of a 16-bit offset, an access kind, a byte-or-word size, a direction and optional write data. It picks the segment base that fits the access kind, or an override base where one is allowed. It forms a 20-bit physical address from the base and the offset. It then runs the request as one or two bus cycles on a 16-bit bus. That bus is split into an even byte bank on the low data lane and an odd byte bank on the high data lane. Each cycle drives the physical address, an active-low high-lane enable and the write data, already moved onto the correct lanes.

Requests enter through a valid/ready handshake. The block holds one request at a time. `req_ready` is high only while the block is idle, so a producer that holds `req_valid` high waits there until the previous request has completed. That wait is the only back-pressure. A request is taken on the clock edge where both `req_valid` and `req_ready` are high.

A word at an odd address is split into two byte cycles: the odd byte first, then the even byte at the next offset. For reads, the two bytes are put back together. A one-cycle `done` pulse marks the end of every request. For reads, that pulse carries the aligned read data.

Top module: `segaddr_lane_gen`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. It appears on `bus_addr` in the first bus cycle. `bus_addr[0]` acts as the even/odd select.
- R2: The segment depends on `req_kind`: 0 = instruction fetch (`seg_code`), 1 = ordinary data (`seg_data`), 2 = stack (`seg_stack`), 3 = string destination (`seg_extra`).
- R3: When `ovr_en` is high, `ovr_seg` replaces the segment for kinds 1 and 2. For kinds 0 and 3, `ovr_en` and `ovr_seg` have no effect.
- R4: `req_ready` is high only in the idle state. After a request is taken, the first bus cycle (`bus_cyc` high) starts on the next cycle. `req_ready` stays low through every bus cycle and is high again in the cycle where `done` pulses.
- R5: Lane enables use `bus_bhe_n` and `bus_addr[0]`:
  - 0/0 selects both lanes.
  - 0/1 selects the odd (high) lane only.
  - 1/0 selects the even (low) lane only.
  - 1/1 is never driven during a bus cycle.
  An even word uses 0/0. A byte uses `bus_bhe_n` = NOT `bus_addr[0]`.
- R6: A byte access and an even-addressed word each take exactly one bus cycle. An odd-addressed word takes two consecutive cycles:
  - first, the odd address with `bus_bhe_n`=0;
  - second, offset+1 with `bus_bhe_n`=1 and `bus_addr[0]`=0.
- R7: `bus_wr` equals the request's direction in every bus cycle. On writes:
  - An even word is driven unchanged.
  - A byte access drives the low data byte on both lanes.
  - A split word drives the low byte on both lanes in the first cycle and the high byte on both lanes in the second.
- R8: Read data returned with `done`:
  - Even byte: `bus_rdata[7:0]`, zero-extended.
  - Odd byte: `bus_rdata[15:8]`, zero-extended.
  - Even word: `bus_rdata` as-is.
  - Split word: {second cycle `bus_rdata[7:0]`, first cycle `bus_rdata[15:8]`}.
- R9: `done` is high for exactly one cycle, in the cycle right after the last bus cycle. `done_rdata` is zero for writes.
- R10: For the second cycle of a split word, offset+1 wraps within 16 bits, so offset FFFF continues at offset 0000 of the same segment. The 20-bit sum also wraps; for example, segment FFFF with offset 0010 gives address 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and takes the offered request |
| req_kind | input | 2 | Access kind: 0 code, 1 data, 2 stack, 3 string destination |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| seg_code | input | 16 | Code segment base |
| seg_data | input | 16 | Data segment base |
| seg_stack | input | 16 | Stack segment base |
| seg_extra | input | 16 | String-destination segment base |
| ovr_en | input | 1 | Request an override segment |
| ovr_seg | input | 16 | Override segment base |
| bus_cyc | output | 1 | A bus cycle is active this clock |
| bus_addr | output | 20 | Physical address; bit 0 selects even or odd |
| bus_bhe_n | output | 1 | Active-low enable of the high (odd) lane |
| bus_wr | output | 1 | Direction of the current bus cycle |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data, sampled at the end of each bus cycle |
| done | output | 1 | One-cycle end-of-request pulse |
| done_rdata | output | 16 | Aligned read data (zero for writes) |

## Verification
The risky state is the phase register together with the latched offset and size. The following faults all appear at the ports within the same request:
- A wrong phase for the split decision shows up as a missing or extra `bus_cyc` cycle.
- A wrong offset increment or wrap shows up as a wrong `bus_addr` in the second cycle.
- A bad held low byte shows up as swapped halves in `done_rdata`.

Two further faults are caught within at most two cycles of the request being taken. A wrong segment choice or a wrongly applied override gives a wrong address in the first bus cycle. A lane-steering error gives the illegal 1/1 enable pair or misplaced write bytes in that same cycle.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  typedef enum logic [1:0] {
    KIND_CODE  = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_STACK = 2'd2,
    KIND_XDST  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/segaddr_segsel.sv
module segaddr_segsel
  import segaddr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [1:0]       kind,
  input  logic [SEG_W-1:0] seg_code,
  input  logic [SEG_W-1:0] seg_data,
  input  logic [SEG_W-1:0] seg_stack,
  input  logic [SEG_W-1:0] seg_extra,
  input  logic             ovr_en,
  input  logic [SEG_W-1:0] ovr_seg,
  output logic [SEG_W-1:0] seg_out
);
  always_comb begin
    unique case (acc_kind_e'(kind))
      KIND_CODE:  seg_out = seg_code;
      KIND_DATA:  seg_out = ovr_en ? ovr_seg : seg_data;
      KIND_STACK: seg_out = ovr_en ? ovr_seg : seg_stack;
      default:    seg_out = seg_extra;
    endcase
  end
endmodule

// File: rtl/segaddr_calc.sv
module segaddr_calc #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] off_w;

  assign base_w = {seg, {SEG_SHIFT{1'b0}}};
  assign off_w  = ADDR_W'(off);
  // the sum is truncated to ADDR_W bits, which gives the modulo wrap
  assign phys   = base_w + off_w;
endmodule

// File: rtl/segaddr_lanes.sv
module segaddr_lanes #(
  parameter int LANE_W = 8,
  localparam int DW    = 2 * LANE_W
) (
  input  logic              is_word,
  input  logic              a0,
  input  logic              phase2,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     rdata,
  output logic              bhe_n,
  output logic [DW-1:0]     lane_wdata,
  output logic [LANE_W-1:0] rd_byte
);
  logic [LANE_W-1:0] w_lo, w_hi;
  assign w_lo = wdata[LANE_W-1:0];
  assign w_hi = wdata[DW-1:LANE_W];

  always_comb begin
    if (phase2) begin
      bhe_n      = 1'b1;
      lane_wdata = {w_hi, w_hi};
    end else if (is_word) begin
      bhe_n      = 1'b0;
      lane_wdata = a0 ? {w_lo, w_lo} : wdata;
    end else begin
      bhe_n      = ~a0;
      lane_wdata = {w_lo, w_lo};
    end
  end

  assign rd_byte = a0 ? rdata[DW-1:LANE_W] : rdata[LANE_W-1:0];
endmodule

// File: rtl/segaddr_lane_gen.sv
module segaddr_lane_gen
  import segaddr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int LANE_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_kind,
  input  logic                         req_word,
  input  logic                         req_write,
  input  logic [OFF_W-1:0]             req_offset,
  input  logic [2*LANE_W-1:0]          req_wdata,
  input  logic [SEG_W-1:0]             seg_code,
  input  logic [SEG_W-1:0]             seg_data,
  input  logic [SEG_W-1:0]             seg_stack,
  input  logic [SEG_W-1:0]             seg_extra,
  input  logic                         ovr_en,
  input  logic [SEG_W-1:0]             ovr_seg,
  output logic                         bus_cyc,
  output logic [SEG_W+SEG_SHIFT-1:0]   bus_addr,
  output logic                         bus_bhe_n,
  output logic                         bus_wr,
  output logic [2*LANE_W-1:0]          bus_wdata,
  input  logic [2*LANE_W-1:0]          bus_rdata,
  output logic                         done,
  output logic [2*LANE_W-1:0]          done_rdata
);
  localparam int ADDR_W = SEG_W + SEG_SHIFT;
  localparam int DW     = 2 * LANE_W;

  phase_e            phase_q;
  logic [SEG_W-1:0]  sel_seg, seg_q;
  logic [OFF_W-1:0]  off_q, off_eff;
  logic              word_q, write_q;
  logic [DW-1:0]     wdata_q;
  logic [LANE_W-1:0] lo_q, rd_byte;
  logic [ADDR_W-1:0] phys;
  logic              accept, phase2, split;
  logic              done_q;
  logic [DW-1:0]     done_rdata_q;

  segaddr_segsel #(.SEG_W(SEG_W)) u_segsel (
    .kind(req_kind), .seg_code(seg_code), .seg_data(seg_data),
    .seg_stack(seg_stack), .seg_extra(seg_extra),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .seg_out(sel_seg)
  );

  assign phase2  = (phase_q == PH_SECOND);
  assign split   = word_q & off_q[0];
  assign off_eff = phase2 ? off_q + OFF_W'(1) : off_q;

  segaddr_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_calc (
    .seg(seg_q), .off(off_eff), .phys(phys)
  );

  segaddr_lanes #(.LANE_W(LANE_W)) u_lanes (
    .is_word(word_q), .a0(phys[0]), .phase2(phase2),
    .wdata(wdata_q), .rdata(bus_rdata),
    .bhe_n(bus_bhe_n), .lane_wdata(bus_wdata), .rd_byte(rd_byte)
  );

  assign req_ready  = (phase_q == PH_IDLE);
  assign accept     = req_valid & req_ready;
  assign bus_cyc    = (phase_q != PH_IDLE);
  assign bus_addr   = phys;
  assign bus_wr     = write_q;
  assign done       = done_q;
  assign done_rdata = done_rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      seg_q        <= '0;
      off_q        <= '0;
      word_q       <= 1'b0;
      write_q      <= 1'b0;
      wdata_q      <= '0;
      lo_q         <= '0;
      done_q       <= 1'b0;
      done_rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          seg_q   <= sel_seg;
          off_q   <= req_offset;
          word_q  <= req_word;
          write_q <= req_write;
          wdata_q <= req_wdata;
          phase_q <= PH_FIRST;
        end
        PH_FIRST: if (split) begin
          lo_q    <= rd_byte;
          phase_q <= PH_SECOND;
        end else begin
          phase_q      <= PH_IDLE;
          done_q       <= 1'b1;
          done_rdata_q <= write_q ? '0 : (word_q ? bus_rdata : DW'(rd_byte));
        end
        default: begin
          phase_q      <= PH_IDLE;
          done_q       <= 1'b1;
          done_rdata_q <= write_q ? '0 : {bus_rdata[LANE_W-1:0], lo_q};
        end
      endcase
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !req_ready); // R4
  AST_ACCEPT_STARTS_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_cyc); // R4
  AST_NO_DEAD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !(bus_bhe_n && bus_addr[0])); // R5
  AST_SECOND_IS_EVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc)) |-> (!bus_addr[0] && bus_bhe_n)); // R6
  AST_SPLIT_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc)) |-> (bus_wr == $past(bus_wr))); // R7
  AST_DONE_AFTER_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_cyc) && !bus_cyc)); // R9
  AST_DONE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: tb/tb_segaddr_lane_gen.sv
module tb_segaddr_lane_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic        req_word = 1'b0, req_write = 1'b0;
  logic [15:0] req_offset = '0, req_wdata = '0;
  logic [15:0] seg_code = 16'h1000, seg_data = 16'h2345;
  logic [15:0] seg_stack = 16'hFFFF, seg_extra = 16'h0ABC;
  logic        ovr_en = 1'b0;
  logic [15:0] ovr_seg = 16'h7F01;
  logic        bus_cyc, bus_bhe_n, bus_wr, done;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata, done_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  segaddr_lane_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_word(req_word), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .seg_code(seg_code), .seg_data(seg_data), .seg_stack(seg_stack),
    .seg_extra(seg_extra), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .done_rdata(done_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
  endfunction

  assign bus_rdata = {mem_byte({bus_addr[19:1], 1'b1}), mem_byte({bus_addr[19:1], 1'b0})};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_one(input logic [1:0] k, input bit ov, input bit wd, input bit wr,
                         input logic [15:0] off, input logic [15:0] wdat);
    logic [15:0] seg;
    logic [19:0] a1, a2;
    logic [20:0] raw;
    bit          spl;
    int          ncyc, done_at, ndone;
    logic [19:0] cad [2];
    logic        cbhe [2];
    logic        cwr [2];
    logic [15:0] cwd [2];
    logic [15:0] crd [2];
    logic [15:0] exp_rd, got_rd;
    bit          ready_bad;
    string       atag;
    case (k)
      2'd0: seg = seg_code;
      2'd1: seg = ov ? ovr_seg : seg_data;
      2'd2: seg = ov ? ovr_seg : seg_stack;
      default: seg = seg_extra;
    endcase
    raw = {1'b0, seg, 4'h0} + {5'h0, off};
    a1  = raw[19:0];
    a2  = {seg, 4'h0} + {4'h0, 16'(off + 16'd1)};
    spl = wd && off[0];

    @(negedge clk);
    req_kind = k; ovr_en = ov; req_word = wd; req_write = wr;
    req_offset = off; req_wdata = wdat; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ncyc = 0; done_at = -1; ndone = 0; got_rd = '0; ready_bad = 0;
    for (int i = 0; i < 5; i++) begin
      if (bus_cyc) begin
        if (req_ready) ready_bad = 1;
        if (ncyc < 2) begin
          cad[ncyc] = bus_addr; cbhe[ncyc] = bus_bhe_n; cwr[ncyc] = bus_wr;
          cwd[ncyc] = bus_wdata; crd[ncyc] = bus_rdata;
        end
        ncyc++;
      end
      if (done) begin
        ndone++; done_at = i; got_rd = done_rdata;
        if (!req_ready) ready_bad = 1;
      end
      @(negedge clk);
    end

    chk(!ready_bad, "R4 ready low while busy, high at done", 32'(ready_bad), 0);
    chk(ncyc == (spl ? 2 : 1), "R6 bus cycle count", 32'(ncyc), spl ? 2 : 1);
    chk(ndone == 1 && done_at == (spl ? 2 : 1), "R9 done single pulse after last cycle",
        32'(done_at), spl ? 2 : 1);
    if (ncyc < 1) return;
    if (raw[20]) atag = "R10 first address wraps";
    else if (ov) atag = "R3 first address with override request";
    else if (k == 2'd1) atag = "R1 first address";
    else atag = "R2 first address by kind";
    chk(cad[0] == a1, atag, 32'(cad[0]), 32'(a1));
    chk(cbhe[0] == ((wd) ? 1'b0 : ~a1[0]), "R5 first cycle high-lane enable",
        32'(cbhe[0]), 32'((wd) ? 1'b0 : ~a1[0]));
    chk(cwr[0] == wr, "R7 first cycle direction", 32'(cwr[0]), 32'(wr));
    if (wr)
      chk(cwd[0] == ((wd && !off[0]) ? wdat : {wdat[7:0], wdat[7:0]}), "R7 first cycle write lanes",
          32'(cwd[0]), 32'((wd && !off[0]) ? wdat : {wdat[7:0], wdat[7:0]}));
    if (spl && ncyc >= 2) begin
      chk(cad[1] == a2, (off == 16'hFFFF) ? "R10 second offset wraps in segment" : "R6 second address",
          32'(cad[1]), 32'(a2));
      chk(cbhe[1] == 1'b1 && cad[1][0] == 1'b0, "R6 second cycle even lane only",
          32'({cbhe[1], cad[1][0]}), 32'h2);
      chk(cwr[1] == wr, "R7 second cycle direction", 32'(cwr[1]), 32'(wr));
      if (wr)
        chk(cwd[1] == {wdat[15:8], wdat[15:8]}, "R7 second cycle write lanes",
            32'(cwd[1]), 32'({wdat[15:8], wdat[15:8]}));
    end
    if (wr) exp_rd = 16'h0;
    else if (spl) exp_rd = {mem_byte(a2), mem_byte(a1)};
    else if (wd) exp_rd = {mem_byte(a1 | 20'h1), mem_byte(a1)};
    else exp_rd = {8'h0, mem_byte(a1)};
    chk(got_rd == exp_rd, wr ? "R9 write returns zero" : "R8 read data alignment",
        32'(got_rd), 32'(exp_rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] offs [7];
    offs = '{16'h0000, 16'h0001, 16'h1234, 16'hF001, 16'hFFFE, 16'hFFFF, 16'h0010};
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R4 reset ready known", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_cyc && !done, "R4 reset idle state",
        32'({req_ready, bus_cyc, done}), 32'h4);
    for (int oi = 0; oi < 7; oi++)
      for (int k = 0; k < 4; k++)
        for (int ov = 0; ov < 2; ov++)
          for (int wd = 0; wd < 2; wd++)
            for (int wr = 0; wr < 2; wr++)
              run_one(2'(k), ov[0], wd[0], wr[0], offs[oi], 16'hA55A ^ 16'(oi * 16'h0321 + k));
    summary();
  end
endmodule